// File: doc/BRIEF.md
# CAN Time Stamp Counter

This block keeps the time base for a CAN controller's receive path. A free-running counter advances once per reference tick. The reference tick is one nominal bit time, reported by the bit timing logic as a single-cycle strobe, and it can be divided by 1, 2, 4 or 8 through a 2-bit select. The count runs without stopping and wraps around.

Software reads the live value through a read strobe. In the same cycle as the strobe, the read port carries the count as it stands. When the protocol engine reports that a frame was received successfully, the count is latched into a holding register. A one-clock valid pulse then tells the receive-slot storage logic to write that stamp next to the frame. All state uses a synchronous reset.

Top module: `can_tstamp`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) clears the live count, the captured stamp and the valid pulse to zero, and also clears the divider phase.
- R2: With div_sel = 0 (divide by 1), every clock with bit_strobe high advances live_count by exactly one at that edge.
- R3: div_sel encodes the divide factor as 2**div_sel: 0 gives 1, 1 gives 2, 2 gives 4 and 3 gives 8. live_count advances once on every 2**div_sel-th counted bit_strobe.
- R4: live_count is 16 bits wide and wraps from 0xFFFF to 0x0000 on the next tick.
- R5: In a clock where div_sel differs from its value in the previous clock, the divider phase restarts and any bit_strobe in that clock is not counted. The first tick after the change therefore comes only after 2**div_sel further strobes.
- R6: While rd_stb is high, ts_read equals live_count in the same cycle. While rd_stb is low, ts_read is zero.
- R7: On a clock edge where rx_ok is high, ts_cap takes the value live_count had before that edge. This holds even if the count increments at the same edge. ts_cap holds its value between captures.
- R8: stamp_vld is high for exactly the one clock that follows each clock with rx_ok high, and is low at all other times.
- R9: In a clock without bit_strobe, live_count does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_strobe | input | 1 | One-cycle pulse per nominal bit time |
| div_sel | input | 2 | Tick divide select, factor 2**div_sel |
| rx_ok | input | 1 | Successful-reception pulse from the protocol engine |
| rd_stb | input | 1 | Register read strobe |
| live_count | output | 16 | Current counter value |
| ts_read | output | 16 | Read data: count while rd_stb is high, else zero |
| ts_cap | output | 16 | Stamp latched at the last successful reception |
| stamp_vld | output | 1 | One-clock pulse after each capture |

## Verification
The random phase sends bit strobes with gaps under every divide select, and it changes the select at unaligned divider phases. The two cases are told apart this way: a divider that ignores the select gives a mismatch as soon as a factor other than 1 is chosen, and one that keeps its phase across a change ticks too early. Receptions arrive at random and sometimes coincide with a tick. This separates capture of the old value from capture of the incremented one. Directed cases check a full run to the 0xFFFF wrap, idle clocks without strobes, and a reset taken from a non-zero state.

// File: rtl/tstamp_pkg.sv
package tstamp_pkg;
  localparam int CNT_W = 16;
  localparam int SEL_W = 2;
  localparam int MAX_DIV = 1 << ((1 << SEL_W) - 1);
  localparam int DIV_W = $clog2(MAX_DIV);

  // last phase index of the divider for a given select
  function automatic logic [DIV_W-1:0] div_last(input logic [SEL_W-1:0] sel);
    return DIV_W'((1 << sel) - 1);
  endfunction

  // counter successor, wraps naturally at the width
  function automatic logic [CNT_W-1:0] count_next(input logic [CNT_W-1:0] c);
    return c + 1'b1;
  endfunction
endpackage

// File: rtl/tstamp_prescaler.sv
module tstamp_prescaler
  import tstamp_pkg::*;
#(
  parameter int S_W = SEL_W,
  parameter int D_W = DIV_W
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           bit_strobe,
  input  logic [S_W-1:0] div_sel,
  output logic           tick,
  output logic           sel_chg
);
  logic [S_W-1:0] sel_q;
  logic [D_W-1:0] phase_q;
  logic           at_last;

  assign sel_chg = (div_sel != sel_q);
  assign at_last = (phase_q == D_W'(div_last(SEL_W'(div_sel))));
  assign tick    = bit_strobe & ~sel_chg & at_last;

  always_ff @(posedge clk) begin
    sel_q <= div_sel;
    if (rst) begin
      phase_q <= '0;
    end else if (sel_chg) begin
      phase_q <= '0;
    end else if (bit_strobe) begin
      phase_q <= at_last ? '0 : phase_q + 1'b1;
    end
  end
endmodule

// File: rtl/tstamp_counter.sv
module tstamp_counter
  import tstamp_pkg::*;
#(
  parameter int C_W = CNT_W
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           tick,
  input  logic           rd_stb,
  output logic [C_W-1:0] count,
  output logic [C_W-1:0] rd_data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else if (tick) begin
      count <= C_W'(count_next(CNT_W'(count)));
    end
  end

  assign rd_data = rd_stb ? count : '0;
endmodule

// File: rtl/tstamp_capture.sv
module tstamp_capture
  import tstamp_pkg::*;
#(
  parameter int C_W = CNT_W
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           rx_ok,
  input  logic [C_W-1:0] count,
  output logic [C_W-1:0] stamp,
  output logic           stamp_vld
);
  always_ff @(posedge clk) begin
    if (rst) begin
      stamp     <= '0;
      stamp_vld <= 1'b0;
    end else begin
      stamp_vld <= rx_ok;
      if (rx_ok) begin
        stamp <= count;
      end
    end
  end
endmodule

// File: rtl/can_tstamp.sv
module can_tstamp
  import tstamp_pkg::*;
#(
  parameter int C_W = CNT_W,
  parameter int S_W = SEL_W,
  parameter int D_W = DIV_W
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           bit_strobe,
  input  logic [S_W-1:0] div_sel,
  input  logic           rx_ok,
  input  logic           rd_stb,
  output logic [C_W-1:0] live_count,
  output logic [C_W-1:0] ts_read,
  output logic [C_W-1:0] ts_cap,
  output logic           stamp_vld
);
  // internal events, visible to the checker
  logic tick;
  logic sel_chg;

  tstamp_prescaler #(.S_W(S_W), .D_W(D_W)) u_pre (
    .clk(clk), .rst(rst), .bit_strobe(bit_strobe), .div_sel(div_sel),
    .tick(tick), .sel_chg(sel_chg)
  );

  tstamp_counter #(.C_W(C_W)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .rd_stb(rd_stb),
    .count(live_count), .rd_data(ts_read)
  );

  tstamp_capture #(.C_W(C_W)) u_cap (
    .clk(clk), .rst(rst), .rx_ok(rx_ok), .count(live_count),
    .stamp(ts_cap), .stamp_vld(stamp_vld)
  );
endmodule

// File: rtl/can_tstamp_chk.sv
module can_tstamp_chk #(
  parameter int C_W = 16
) (
  input logic           clk,
  input logic           rst,
  input logic           bit_strobe,
  input logic           rx_ok,
  input logic           rd_stb,
  input logic           tick,
  input logic           sel_chg,
  input logic [C_W-1:0] live_count,
  input logic [C_W-1:0] ts_read,
  input logic [C_W-1:0] ts_cap,
  input logic           stamp_vld
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (live_count == '0 && ts_cap == '0 && !stamp_vld));

  // R2
  tick_step_chk: assert property (@(posedge clk) disable iff (rst)
    tick |=> live_count == C_W'($past(live_count) + 1'b1));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !bit_strobe |=> $stable(live_count));

  // R5
  sel_change_no_tick_chk: assert property (@(posedge clk) disable iff (rst)
    sel_chg |-> !tick);

  // R6
  read_live_chk: assert property (@(posedge clk) disable iff (rst)
    rd_stb |-> ts_read == live_count);

  // R6
  read_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_stb |-> ts_read == '0);

  // R7
  capture_old_chk: assert property (@(posedge clk) disable iff (rst)
    rx_ok |=> ts_cap == $past(live_count));

  // R7
  capture_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rx_ok |=> $stable(ts_cap));

  // R8
  vld_after_rx_chk: assert property (@(posedge clk) disable iff (rst)
    rx_ok |=> stamp_vld);

  // R8
  vld_only_after_rx_chk: assert property (@(posedge clk) disable iff (rst)
    !rx_ok |=> !stamp_vld);
endmodule

bind can_tstamp can_tstamp_chk #(.C_W(C_W)) u_chk (
  .clk(clk), .rst(rst), .bit_strobe(bit_strobe), .rx_ok(rx_ok),
  .rd_stb(rd_stb), .tick(tick), .sel_chg(sel_chg),
  .live_count(live_count), .ts_read(ts_read), .ts_cap(ts_cap),
  .stamp_vld(stamp_vld)
);

// File: tb/can_tstamp_bench.sv
`timescale 1ns/1ps
module can_tstamp_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bit_strobe = 1'b0;
  logic [1:0]  div_sel = 2'd0;
  logic        rx_ok = 1'b0;
  logic        rd_stb = 1'b0;
  logic [15:0] live_count, ts_read, ts_cap;
  logic        stamp_vld;

  int total = 0;
  int bad = 0;

  // reference model state
  logic [15:0] m_cnt = '0;
  logic [15:0] m_cap = '0;
  logic        m_vld = 1'b0;
  logic [3:0]  m_phase = '0;
  logic [1:0]  m_sel = 2'd0;

  always #4 clk = ~clk;

  can_tstamp u_can_tstamp (
    .clk(clk), .rst(rst), .bit_strobe(bit_strobe), .div_sel(div_sel),
    .rx_ok(rx_ok), .rd_stb(rd_stb), .live_count(live_count),
    .ts_read(ts_read), .ts_cap(ts_cap), .stamp_vld(stamp_vld)
  );

  // divide factor stated by the select encoding (R3)
  function automatic int factor_of(input logic [1:0] sel);
    case (sel)
      2'd0: return 1;
      2'd1: return 2;
      2'd2: return 4;
      default: return 8;
    endcase
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic s, input logic [1:0] sel, input logic rx, input logic rd);
    logic changed, tk;
    @(negedge clk);
    bit_strobe = s; div_sel = sel; rx_ok = rx; rd_stb = rd;
    #1;
    check("R6 read data", ts_read, rd ? m_cnt : 16'h0);
    changed = (sel != m_sel);
    tk = 1'b0;
    if (changed) m_phase = 0;
    else if (s) begin
      if (int'(m_phase) + 1 == factor_of(sel)) begin
        tk = 1'b1;
        m_phase = 0;
      end else m_phase = m_phase + 1;
    end
    m_vld = rx;
    if (rx) m_cap = m_cnt;
    if (tk) m_cnt = m_cnt + 16'd1;
    m_sel = sel;
    @(posedge clk); #1;
    check("R3 live count", live_count, m_cnt);
    check("R7 captured stamp", ts_cap, m_cap);
    check("R8 stamp valid", {15'd0, stamp_vld}, {15'd0, m_vld});
  endtask

  task automatic do_reset(input logic [1:0] sel);
    @(negedge clk);
    rst = 1'b1; bit_strobe = 1'b0; rx_ok = 1'b0; rd_stb = 1'b0; div_sel = sel;
    repeat (2) @(posedge clk);
    #1;
    check("R1 count after reset", live_count, 16'h0);
    check("R1 stamp after reset", ts_cap, 16'h0);
    check("R1 valid after reset", {15'd0, stamp_vld}, 16'h0);
    @(negedge clk); rst = 1'b0;
    m_cnt = '0; m_cap = '0; m_vld = 1'b0; m_phase = '0; m_sel = sel;
  endtask

  initial begin
    #(8 * 200000);
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] base;
    void'($urandom(32'd1234));
    do_reset(2'd0);

    // R2: divide by one, one tick per strobe
    base = live_count;
    for (int i = 0; i < 5; i++) step(1'b1, 2'd0, 1'b0, 1'b0);
    check("R2 five strobes", live_count, base + 16'd5);

    // R9: no strobe, no change
    base = live_count;
    for (int i = 0; i < 6; i++) step(1'b0, 2'd0, 1'b0, 1'b1);
    check("R9 idle hold", live_count, base);

    // R3: divide by eight
    step(1'b0, 2'd3, 1'b0, 1'b0);
    base = live_count;
    for (int i = 0; i < 7; i++) step(1'b1, 2'd3, 1'b0, 1'b0);
    check("R3 seven of eight", live_count, base);
    step(1'b1, 2'd3, 1'b0, 1'b0);
    check("R3 eighth strobe", live_count, base + 16'd1);

    // R5: change select mid-phase, strobe in change cycle ignored
    for (int i = 0; i < 3; i++) step(1'b1, 2'd3, 1'b0, 1'b0);
    base = live_count;
    step(1'b1, 2'd1, 1'b0, 1'b0);
    step(1'b1, 2'd1, 1'b0, 1'b0);
    check("R5 no early tick", live_count, base);
    step(1'b1, 2'd1, 1'b0, 1'b0);
    check("R5 full period tick", live_count, base + 16'd1);

    // R7: capture coincident with tick keeps old value
    step(1'b0, 2'd0, 1'b0, 1'b0);
    base = live_count;
    step(1'b1, 2'd0, 1'b1, 1'b0);
    check("R7 coincident capture", ts_cap, base);
    check("R7 count still ticks", live_count, base + 16'd1);
    check("R8 valid pulse", {15'd0, stamp_vld}, 16'd1);
    step(1'b0, 2'd0, 1'b0, 1'b0);
    check("R8 valid drops", {15'd0, stamp_vld}, 16'd0);

    // random phase
    for (int i = 0; i < 20000; i++) begin
      logic [1:0] sel;
      sel = (($urandom % 16) == 0) ? 2'($urandom % 4) : m_sel;
      step(1'(($urandom % 2) == 0), sel, 1'(($urandom % 8) == 0), 1'(($urandom % 4) == 0));
    end

    // R1: reset from non-zero state
    do_reset(2'd0);

    // R4: run to the wrap point
    while (m_cnt != 16'hFFFF) step(1'b1, 2'd0, 1'b0, 1'b0);
    check("R4 at max", live_count, 16'hFFFF);
    step(1'b1, 2'd0, 1'b0, 1'b1);
    check("R4 wrapped", live_count, 16'h0000);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule